// File: doc/BRIEF.md
# Hybrid Hash-CAM Signature Matcher

This block checks one 128-bit word per clock against a preloaded set of signatures. For each word it reports whether the word equals a stored signature and, if so, the 16-bit signature ID. Most signatures live in two hash-addressed RAM banks. A hash slot can hold up to two signatures, one in each bank. Signatures that do not fit in their slot are placed in a small fully associative table. That table is searched in the same cycle as the banks, so every lookup takes the same number of cycles however crowded the hash table is.

The hash key is a 16-bit CRC over the word, cut down to its low bits. A software-side tool decides where each signature goes and then loads it through a write port: bank 1 slot, bank 2 slot or associative entry, each selected by address. Loading happens only while no lookups are in flight.

Top module: `hcam_matcher`

## Requirements
- R1: The hash slot of a word is the low HASH_W (default 12) bits of a CRC-16 with a zero start value. The CRC takes the word's bits from bit 0 upward. For each bit it shifts the register right and XORs in 0xA001 when the bit XOR the old register bit 0 is 1. A word matches a bank entry only at its own hash slot.
- R2: A word equal to the valid bank 1 entry at its slot gives out_match=1, out_bank_hit[0]=1 and out_sid equal to that entry's ID.
- R3: A word equal to the valid bank 2 entry at its slot gives out_bank_hit[1]=1. If bank 1 misses, out_sid is that entry's ID.
- R4: A word equal to any valid associative entry gives out_cam_hit=1. When several entries match, the lowest-index entry's ID is used.
- R5: When several paths hit, out_sid is taken from bank 1 first, then bank 2, then the associative table. A lookup that misses everywhere gives out_match=0 and out_sid=0.
- R6: An entry whose valid bit is 0 never matches. Writing an entry with wr_vld=0 removes it, and reset clears every valid bit.
- R7: A lookup with in_valid high at a rising edge gives out_valid high right after the second rising edge that follows it. A new word can be accepted on every clock. While out_valid is 0, all hit flags and out_sid are 0.
- R8: With wr_en high, wr_sel selects the target: 0 for bank 1, 1 for bank 2, 2 for the associative table (index = low bits of wr_addr). An entry written at one edge is seen by a lookup sampled at the next edge.
- R9: A write with wr_sel=3 changes nothing.
- R10: During and right after reset, out_valid, out_match, out_bank_hit, out_cam_hit and out_sid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lookup word present |
| in_word | input | 128 | Word to look up |
| wr_en | input | 1 | Load strobe |
| wr_sel | input | 2 | Load target: 0 bank 1, 1 bank 2, 2 associative, 3 none |
| wr_addr | input | HASH_W | Bank slot, or associative index in its low bits |
| wr_vld | input | 1 | Valid bit written with the entry |
| wr_pat | input | 128 | Signature pattern to store |
| wr_sid | input | 16 | Signature ID to store |
| out_valid | output | 1 | Result present |
| out_match | output | 1 | Some path hit |
| out_bank_hit | output | 2 | Bit 0 bank 1 hit, bit 1 bank 2 hit |
| out_cam_hit | output | 1 | Associative table hit |
| out_sid | output | 16 | ID of the winning path, 0 on a miss |

## Verification
The assertions assume that wr_en and in_valid are never high in the same cycle. One of them checks this input rule directly. The latency and write-visibility properties also depend on it, because a write must not land under a read that is in flight. The bench keeps to the rule by loading only in cycles with in_valid low, and it streams lookups only once loading is finished. Writes that come directly before a lookup are placed one edge ahead, so the next-cycle visibility rule is exercised at its tightest.

// File: rtl/hcam_pkg.sv
package hcam_pkg;
    localparam int DATA_W        = 128;
    localparam int SID_W         = 16;
    localparam int CRC_W         = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'hA001;
    localparam int HASH_W_DEF    = 12;
    localparam int CAM_DEPTH_DEF = 64;

    typedef enum logic [1:0] {
        SEL_BANK1 = 2'd0,
        SEL_BANK2 = 2'd1,
        SEL_CAM   = 2'd2,
        SEL_NONE  = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic              vld;
        logic [SID_W-1:0]  sid;
        logic [DATA_W-1:0] pat;
    } entry_t;

    typedef struct packed {
        logic             hit;
        logic [SID_W-1:0] sid;
    } path_res_t;
endpackage

// File: rtl/hcam_hash.sv
module hcam_hash
    import hcam_pkg::*;
#(
    parameter int HASH_W = HASH_W_DEF
) (
    input  logic [DATA_W-1:0] word,
    output logic [HASH_W-1:0] key
);
    logic [CRC_W-1:0] crc;

    // Reflected CRC, one input bit per step, bit 0 of the word first.
    always_comb begin
        crc = '0;
        for (int i = 0; i < DATA_W; i++) begin
            crc = {1'b0, crc[CRC_W-1:1]} ^ ({CRC_W{crc[0] ^ word[i]}} & CRC_POLY);
        end
    end

    assign key = crc[HASH_W-1:0];
endmodule

// File: rtl/hcam_bank.sv
module hcam_bank
    import hcam_pkg::*;
#(
    parameter int HASH_W = HASH_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [HASH_W-1:0] wr_addr,
    input  entry_t            wr_entry,
    input  logic [HASH_W-1:0] rd_addr,
    output entry_t            rd_entry
);
    localparam int DEPTH = 1 << HASH_W;
    localparam int BODY_W = SID_W + DATA_W;

    logic [BODY_W-1:0] body [DEPTH];
    logic [DEPTH-1:0]  vld;

    always_ff @(posedge clk) begin
        if (wr_en) body[wr_addr] <= {wr_entry.sid, wr_entry.pat};
    end

    always_ff @(posedge clk) begin
        if (rst)        vld <= '0;
        else if (wr_en) vld[wr_addr] <= wr_entry.vld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_entry <= '0;
        end else begin
            rd_entry.vld <= vld[rd_addr];
            rd_entry.sid <= body[rd_addr][BODY_W-1:DATA_W];
            rd_entry.pat <= body[rd_addr][DATA_W-1:0];
        end
    end

    // A write followed by a read of the same slot returns what was written.
    assert_wr_then_rd_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((rd_addr == $past(wr_addr) && !wr_en) |=> (rd_entry == $past(wr_entry, 2))))
        else $error("bank read after write mismatch");
endmodule

// File: rtl/hcam_cam.sv
module hcam_cam
    import hcam_pkg::*;
#(
    parameter int DEPTH = CAM_DEPTH_DEF,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  entry_t            wr_entry,
    input  logic [DATA_W-1:0] key,
    output path_res_t         res
);
    entry_t            ent   [DEPTH];
    logic [DEPTH-1:0]  match;
    logic [DEPTH-1:0]  grant;
    logic [SID_W-1:0]  sid_or;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                                   ent[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))     ent[g] <= wr_entry;
        end
        assign match[g] = ent[g].vld && (ent[g].pat == key);
    end

    // Isolate the lowest set match bit, then AND-OR the IDs.
    assign grant = match & (~match + DEPTH'(1));

    always_comb begin
        sid_or = '0;
        for (int i = 0; i < DEPTH; i++) begin
            sid_or = sid_or | ({SID_W{grant[i]}} & ent[i].sid);
        end
    end

    assign res.hit = |match;
    assign res.sid = sid_or;

    assert_cam_one_grant_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((|grant) == res.hit))
        else $error("associative grant not one-hot or disagrees with hit");
endmodule

// File: rtl/hcam_matcher.sv
module hcam_matcher
    import hcam_pkg::*;
#(
    parameter int HASH_W    = HASH_W_DEF,
    parameter int CAM_DEPTH = CAM_DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [127:0]      in_word,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HASH_W-1:0] wr_addr,
    input  logic              wr_vld,
    input  logic [127:0]      wr_pat,
    input  logic [15:0]       wr_sid,
    output logic              out_valid,
    output logic              out_match,
    output logic [1:0]        out_bank_hit,
    output logic              out_cam_hit,
    output logic [15:0]       out_sid
);
    localparam int CAM_IDX_W = $clog2(CAM_DEPTH);
    localparam int NBANK     = 2;

    entry_t            wr_ent;
    logic [HASH_W-1:0] key_in;
    wr_sel_e           sel;

    // Stage 1: hashed key and delayed word
    logic              s1_vld;
    logic [DATA_W-1:0] s1_word;
    logic [HASH_W-1:0] s1_key;
    // Stage 2: bank read data, delayed word, delayed associative result
    logic              s2_vld;
    logic [DATA_W-1:0] s2_word;
    path_res_t         s2_cam;
    path_res_t         cam_now;
    entry_t            rd_ent [NBANK];
    logic [NBANK-1:0]  bank_hit;
    logic              cam_hit;
    logic [SID_W-1:0]  win_sid;

    assign sel    = wr_sel_e'(wr_sel);
    assign wr_ent = '{vld: wr_vld, sid: wr_sid, pat: wr_pat};

    hcam_hash #(.HASH_W(HASH_W)) u_hash (
        .word (in_word),
        .key  (key_in)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld  <= 1'b0;
            s1_word <= '0;
            s1_key  <= '0;
        end else begin
            s1_vld  <= in_valid;
            s1_word <= in_word;
            s1_key  <= key_in;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        hcam_bank #(.HASH_W(HASH_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && sel == wr_sel_e'(b)),
            .wr_addr  (wr_addr),
            .wr_entry (wr_ent),
            .rd_addr  (s1_key),
            .rd_entry (rd_ent[b])
        );
        assign bank_hit[b] = s2_vld && rd_ent[b].vld && (rd_ent[b].pat == s2_word);
    end

    hcam_cam #(.DEPTH(CAM_DEPTH), .IDX_W(CAM_IDX_W)) u_cam (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en && sel == SEL_CAM),
        .wr_idx   (wr_addr[CAM_IDX_W-1:0]),
        .wr_entry (wr_ent),
        .key      (s1_word),
        .res      (cam_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld  <= 1'b0;
            s2_word <= '0;
            s2_cam  <= '0;
        end else begin
            s2_vld  <= s1_vld;
            s2_word <= s1_word;
            s2_cam  <= cam_now;
        end
    end

    assign cam_hit = s2_vld && s2_cam.hit;

    // Fixed priority: bank 1, bank 2, associative table.
    always_comb begin
        if (bank_hit[0])      win_sid = rd_ent[0].sid;
        else if (bank_hit[1]) win_sid = rd_ent[1].sid;
        else if (cam_hit)     win_sid = s2_cam.sid;
        else                  win_sid = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_match    <= 1'b0;
            out_bank_hit <= '0;
            out_cam_hit  <= 1'b0;
            out_sid      <= '0;
        end else begin
            out_valid    <= s2_vld;
            out_match    <= |bank_hit || cam_hit;
            out_bank_hit <= bank_hit;
            out_cam_hit  <= cam_hit;
            out_sid      <= win_sid;
        end
    end

    // Edges since reset, saturating; lets the latency check look back safely.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)))
        else $error("result not three edges after lookup");

    assert_no_load_in_lookup_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && in_valid))
        else $error("load and lookup in the same cycle");

    assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !s2_vld |=> (!out_match && out_bank_hit == '0 && !out_cam_hit && out_sid == '0))
        else $error("result flags set without a lookup");
endmodule

// File: tb/tb_hcam_matcher.sv
module tb_hcam_matcher;
    localparam int HW    = 12;
    localparam int DEPTH = 1 << HW;
    localparam int CAMN  = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [127:0]  in_word = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [HW-1:0] wr_addr = '0;
    logic          wr_vld = 1'b0;
    logic [127:0]  wr_pat = '0;
    logic [15:0]   wr_sid = '0;
    logic          out_valid, out_match, out_cam_hit;
    logic [1:0]    out_bank_hit;
    logic [15:0]   out_sid;

    always #2 clk = ~clk;

    hcam_matcher dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_vld(wr_vld),
        .wr_pat(wr_pat), .wr_sid(wr_sid), .out_valid(out_valid),
        .out_match(out_match), .out_bank_hit(out_bank_hit),
        .out_cam_hit(out_cam_hit), .out_sid(out_sid)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Reference tables
    logic [127:0] m1_pat [DEPTH]; logic [15:0] m1_sid [DEPTH]; logic m1_v [DEPTH];
    logic [127:0] m2_pat [DEPTH]; logic [15:0] m2_sid [DEPTH]; logic m2_v [DEPTH];
    logic [127:0] mc_pat [CAMN];  logic [15:0] mc_sid [CAMN];  logic mc_v [CAMN];

    int    q_due [$];
    logic [19:0] q_exp [$];   // {match, bank_hit[1:0], cam_hit, sid}
    string q_tag [$];

    function automatic logic [HW-1:0] ref_hash(input logic [127:0] w);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < 128; i++) begin
            logic fb = c[0] ^ w[i];
            c = c >> 1;
            if (fb) c = c ^ 16'hA001;
        end
        return c[HW-1:0];
    endfunction

    function automatic logic [19:0] ref_lookup(input logic [127:0] w);
        logic [HW-1:0] h = ref_hash(w);
        logic b1 = m1_v[h] && m1_pat[h] == w;
        logic b2 = m2_v[h] && m2_pat[h] == w;
        logic ch = 1'b0;
        logic [15:0] csid = '0;
        logic [15:0] sid;
        for (int i = CAMN - 1; i >= 0; i--) begin
            if (mc_v[i] && mc_pat[i] == w) begin ch = 1'b1; csid = mc_sid[i]; end
        end
        sid = b1 ? m1_sid[h] : b2 ? m2_sid[h] : ch ? csid : 16'h0;
        return {b1 | b2 | ch, b2, b1, ch, sid};
    endfunction

    function automatic logic [127:0] rand128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic clear_model();
        for (int i = 0; i < DEPTH; i++) begin m1_v[i] = 1'b0; m2_v[i] = 1'b0; end
        for (int i = 0; i < CAMN; i++) mc_v[i] = 1'b0;
    endtask

    task automatic check_out();
        logic [19:0] got = {out_match, out_bank_hit, out_cam_hit, out_sid};
        if (out_valid) begin
            checks++;
            if (q_due.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected out_valid at cycle %0d: got 1 expected 0", cyc);
            end else begin
                int due = q_due.pop_front();
                logic [19:0] exp = q_exp.pop_front();
                string tag = q_tag.pop_front();
                if (due != cyc) begin
                    errors++;
                    $display("FAIL R7 result cycle: got %0d expected %0d", cyc, due);
                end
                checks++;
                if (got != exp) begin
                    errors++;
                    $display("FAIL %s result: got %h expected %h", tag, got, exp);
                end
            end
        end else begin
            if (q_due.size() != 0 && q_due[0] == cyc) begin
                checks++; errors++;
                $display("FAIL R7 missing result at cycle %0d: got 0 expected 1", cyc);
                void'(q_due.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
            end
            if (got != '0) begin
                checks++; errors++;
                $display("FAIL R7 idle outputs: got %h expected 0", got);
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        check_out();
        in_valid = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] s, input logic [HW-1:0] a, input logic v,
                            input logic [127:0] p, input logic [15:0] id);
        step();
        wr_en = 1'b1; wr_sel = s; wr_addr = a; wr_vld = v; wr_pat = p; wr_sid = id;
        case (s)
            2'd0: begin m1_v[a] = v; m1_pat[a] = p; m1_sid[a] = id; end
            2'd1: begin m2_v[a] = v; m2_pat[a] = p; m2_sid[a] = id; end
            2'd2: begin mc_v[a[5:0]] = v; mc_pat[a[5:0]] = p; mc_sid[a[5:0]] = id; end
            default: ;
        endcase
    endtask

    task automatic do_lookup(input logic [127:0] w, input string tag);
        step();
        in_valid = 1'b1; in_word = w;
        q_due.push_back(cyc + 3);
        q_exp.push_back(ref_lookup(w));
        q_tag.push_back(tag);
    endtask

    task automatic expect_fields(input logic [127:0] w, input logic [19:0] exp, input string tag);
        checks++;
        if (ref_lookup(w) != exp) begin
            errors++;
            $display("FAIL %s reference: got %h expected %h", tag, ref_lookup(w), exp);
        end
        do_lookup(w, tag);
    endtask

    task automatic drain();
        for (int i = 0; i < 5; i++) step();
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [127:0] known [256];

    initial begin
        logic [127:0] w1, w2, w3, w4, w5, w6, w7;
        logic [HW-1:0] h;
        int nk;
        int cam_next;
        void'($urandom(32'd20240917));
        clear_model();

        // R10: outputs during and after reset
        repeat (4) begin
            @(negedge clk);
            checks++;
            if ({out_valid, out_match, out_bank_hit, out_cam_hit, out_sid} != '0) begin
                errors++;
                $display("FAIL R10 reset outputs: got %b expected 0", out_valid);
            end
        end
        rst = 1'b0;
        drain();

        // R2 / R8: load bank 1 and look up on the very next edge
        w1 = rand128(); h = ref_hash(w1);
        do_write(2'd0, h, 1'b1, w1, 16'h0011);
        expect_fields(w1, {1'b1, 2'b01, 1'b0, 16'h0011}, "R2 R8 bank1 hit");
        // R1: word stored at a slot that is not its hash slot does not match
        w2 = rand128();
        do_write(2'd0, ref_hash(w2) + HW'(1), 1'b1, w2, 16'h0022);
        expect_fields(w2, 20'h0, "R1 wrong slot misses");
        // R3: bank 2 only
        w3 = rand128();
        do_write(2'd1, ref_hash(w3), 1'b1, w3, 16'h0033);
        expect_fields(w3, {1'b1, 2'b10, 1'b0, 16'h0033}, "R3 bank2 hit");
        // R4: two associative entries, lowest index wins
        w4 = rand128();
        do_write(2'd2, HW'(7), 1'b1, w4, 16'h0407);
        do_write(2'd2, HW'(3), 1'b1, w4, 16'h0403);
        expect_fields(w4, {1'b1, 2'b00, 1'b1, 16'h0403}, "R4 lowest index");
        // R5: all three paths, then remove in priority order (R6)
        w5 = rand128(); h = ref_hash(w5);
        do_write(2'd0, h, 1'b1, w5, 16'h0A01);
        do_write(2'd1, h, 1'b1, w5, 16'h0A02);
        do_write(2'd2, HW'(10), 1'b1, w5, 16'h0A03);
        expect_fields(w5, {1'b1, 2'b11, 1'b1, 16'h0A01}, "R5 bank1 first");
        do_write(2'd0, h, 1'b0, w5, 16'h0A01);
        expect_fields(w5, {1'b1, 2'b10, 1'b1, 16'h0A02}, "R5 R6 bank2 next");
        do_write(2'd1, h, 1'b0, w5, 16'h0A02);
        expect_fields(w5, {1'b1, 2'b00, 1'b1, 16'h0A03}, "R5 R6 cam last");
        do_write(2'd2, HW'(10), 1'b0, w5, 16'h0A03);
        expect_fields(w5, 20'h0, "R6 all removed");
        // R9: select 3 stores nothing, existing bank 1 entry untouched
        w6 = rand128();
        do_write(2'd3, ref_hash(w6), 1'b1, w6, 16'h0066);
        expect_fields(w6, 20'h0, "R9 select 3 ignored");
        do_write(2'd3, ref_hash(w1), 1'b1, w6, 16'h0067);
        expect_fields(w1, {1'b1, 2'b01, 1'b0, 16'h0011}, "R9 bank1 kept");
        // R7: back-to-back lookups
        do_lookup(w1, "R7 stream a");
        do_lookup(w3, "R7 stream b");
        do_lookup(w4, "R7 stream c");
        drain();
        // R6: reset clears all valid bits
        step();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        clear_model();
        expect_fields(w1, 20'h0, "R6 reset clears bank1");
        expect_fields(w4, 20'h0, "R6 reset clears cam");
        drain();

        // Random load: fill bank 1, then bank 2, then associative table
        cam_next = 0;
        nk = 0;
        for (int i = 0; i < 256; i++) begin
            w7 = rand128(); h = ref_hash(w7);
            if (i % 8 == 0 && cam_next < CAMN) begin
                do_write(2'd2, HW'(cam_next), 1'b1, w7, 16'(16'h8000 + i)); cam_next++;
            end else if (!m1_v[h]) do_write(2'd0, h, 1'b1, w7, 16'(16'h1000 + i));
            else if (!m2_v[h])     do_write(2'd1, h, 1'b1, w7, 16'(16'h2000 + i));
            else if (cam_next < CAMN) begin
                do_write(2'd2, HW'(cam_next), 1'b1, w7, 16'(16'h8000 + i)); cam_next++;
            end
            known[nk] = w7; nk++;
        end
        // Random streaming lookups, mixed hits and misses (R2 R3 R4 R5 R7)
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 4 != 0) begin
                if ($urandom % 3 != 0) do_lookup(known[$urandom % nk], "R2 R3 R4 R5 random hit");
                else                   do_lookup(rand128(), "R5 random miss");
            end else begin
                step();
            end
        end
        drain();
        checks++;
        if (q_due.size() != 0) begin
            errors++;
            $display("FAIL R7 pending results: got %0d expected 0", q_due.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule